// File: doc/BRIEF.md
# Byte-Addressable Load/Store Unit

This unit connects the memory stage of a processor pipeline to a data memory that is one 32-bit word wide. A request carries a base register value, a signed 16-bit displacement, one of four operations and, for stores, the source register value. In the request cycle the unit forms the effective address and drives the word address, the per-byte write enables and the write data toward memory. It also raises an error flag when a word access is not aligned.

The memory answers a read one clock after it sees the address. The unit keeps the few bits of request context it needs for that one cycle, and formats the returned word into the load result. A word load passes the word through unchanged. A byte load picks the addressed byte and sign-extends it. Byte lanes are big-endian: byte offset 0 is the most significant byte of the word.

Operation codes on `req_op` are: 00 load word, 01 store word, 10 load byte, 11 store byte.

Top module: `ls_unit`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits, modulo 2^32. `mem_addr` equals bits 31:2 of that sum in the same cycle as the request.
- R2: `misalign` is high in the request cycle exactly when `req_valid` is high, the operation is a word access (00 or 01) and the effective address bits 1:0 are not zero. Byte operations never raise it.
- R3: An aligned store word drives `mem_we` = 4'b1111 and `mem_wdata` = `store_data`, with `store_data[31:24]` going to the lowest byte address of the word.
- R4: A store byte at byte offset k (effective address bits 1:0) asserts only `mem_we` bit 3-k, where `mem_we` bit i covers `mem_wdata` bits 8i+7:8i. It drives `store_data[7:0]` on all four lanes of `mem_wdata`. The other bytes of the word stay unchanged.
- R5: A misaligned store word drives `mem_we` = 0, so memory keeps its contents.
- R6: Loads and idle cycles (`req_valid` low) drive `mem_we` = 0.
- R7: `load_valid` is high in the cycle after a load request and low in the cycle after any other cycle.
- R8: A byte load at byte offset k returns bits 31-8k:24-8k of the memory word in `load_data[7:0]`. Bits 31:8 are copies of bit 7 of that byte.
- R9: A misaligned load word returns `load_data` = 0 with `load_valid` high.
- R10: While `rst_n` is low and right after its release, `load_valid` is low and, with no request, `mem_we` is 0.
- R11: An aligned load word returns the memory word unchanged in `load_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation: 00 load word, 01 store word, 10 load byte, 11 store byte |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 30 | Word address toward memory |
| mem_we | output | 4 | Byte write enables, bit i for data bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Word returned by memory one cycle after the address |
| misalign | output | 1 | Word access with an address that is not a multiple of 4 |
| load_valid | output | 1 | `load_data` holds a load result |
| load_data | output | 32 | Formatted load result |

## Verification
The bound checker checks, on every cycle, the rules that can be seen at the ports of a single cycle or a pair of cycles:
- a byte store enables one lane and copies its byte to all four lanes;
- a misaligned access, a load and an idle cycle write nothing;
- byte operations never raise the error flag;
- a result appears exactly one cycle after a load;
- a byte-load result is sign-filled;
- a misaligned load word returns zero.

Only the bench's scenarios can show the remaining behaviour: that the effective address, including negative displacements, reaches the right word, and that a store byte lands in the big-endian lane its offset names while its neighbours survive. They also show that a misaligned store leaves the word intact and that loads return what earlier stores left in a byte memory. All of these are compared against a separate shadow copy of memory.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_STW = 2'b01,
    OP_LDB = 2'b10,
    OP_STB = 2'b11
  } lsu_op_e;

  // bit 0 of the code marks a store, bit 1 marks a byte access
  function automatic logic op_is_store(input logic [1:0] op);
    return op[0];
  endfunction

  function automatic logic op_is_word(input logic [1:0] op);
    return ~op[1];
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        base,
  input  logic [OFF_W-1:0]         offset,
  output logic [ADDR_W-LANE_W-1:0] word_addr,
  output logic [LANE_W-1:0]        lane,
  output logic                     misalign
);
  import lsu_pkg::*;

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] eff_addr;

  always_comb begin
    off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
    eff_addr  = base + off_ext;
    word_addr = eff_addr[ADDR_W-1:LANE_W];
    lane      = eff_addr[LANE_W-1:0];
    misalign  = req_valid & op_is_word(req_op) & (|eff_addr[LANE_W-1:0]);
  end

endmodule

// File: rtl/lsu_store.sv
module lsu_store #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [LANE_W-1:0] lane,
  input  logic              misalign,
  input  logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  mem_we,
  output logic [DATA_W-1:0] mem_wdata
);
  import lsu_pkg::*;

  logic do_store;
  logic word_op;

  always_comb begin
    do_store = req_valid & op_is_store(req_op);
    word_op  = op_is_word(req_op);
  end

  // big-endian lanes: byte offset k lives in enable bit LANES-1-k
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int OFS = LANES - 1 - i;
    logic hit;
    always_comb begin
      hit = (lane == LANE_W'(OFS));
      mem_we[i] = do_store & (word_op ? ~misalign : hit);
      mem_wdata[8*i +: 8] = word_op ? store_data[8*i +: 8] : store_data[7:0];
    end
  end

endmodule

// File: rtl/lsu_resp.sv
module lsu_resp #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [LANE_W-1:0] lane,
  input  logic              misalign,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);
  import lsu_pkg::*;

  typedef struct packed {
    logic              vld;
    logic              byte_op;
    logic              err;
    logic [LANE_W-1:0] lane;
  } ctx_t;

  ctx_t ctx_d;
  ctx_t ctx_q;
  logic ctx_en;

  // next state
  always_comb begin
    ctx_d     = ctx_q;
    ctx_d.vld = req_valid & ~op_is_store(req_op);
    if (req_valid) begin
      ctx_d.byte_op = ~op_is_word(req_op);
      ctx_d.err     = misalign;
      ctx_d.lane    = lane;
    end
    ctx_en = req_valid | ctx_q.vld;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (ctx_en) begin
      ctx_q <= ctx_d;
    end
  end

  // byte pick, offset 0 = most significant byte
  logic [7:0] bytes [LANES];
  for (genvar k = 0; k < LANES; k++) begin : g_pick
    always_comb bytes[k] = mem_rdata[DATA_W-1-8*k -: 8];
  end

  logic [7:0] sel_byte;

  always_comb begin
    sel_byte   = bytes[ctx_q.lane];
    load_valid = ctx_q.vld;
    if (ctx_q.err) begin
      load_data = '0;
    end else if (ctx_q.byte_op) begin
      load_data = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
    end else begin
      load_data = mem_rdata;
    end
  end

endmodule

// File: rtl/ls_unit.sv
module ls_unit #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  input  logic [1:0]                                req_op,
  input  logic [ADDR_W-1:0]                         base,
  input  logic [OFF_W-1:0]                          offset,
  input  logic [DATA_W-1:0]                         store_data,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]        mem_addr,
  output logic [DATA_W/8-1:0]                       mem_we,
  output logic [DATA_W-1:0]                         mem_wdata,
  input  logic [DATA_W-1:0]                         mem_rdata,
  output logic                                      misalign,
  output logic                                      load_valid,
  output logic [DATA_W-1:0]                         load_data
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] lane;

  lsu_agen #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .LANE_W (LANE_W)
  ) u_agen (
    .req_valid (req_valid),
    .req_op    (req_op),
    .base      (base),
    .offset    (offset),
    .word_addr (mem_addr),
    .lane      (lane),
    .misalign  (misalign)
  );

  lsu_store #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_store (
    .req_valid  (req_valid),
    .req_op     (req_op),
    .lane       (lane),
    .misalign   (misalign),
    .store_data (store_data),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
  );

  lsu_resp #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .lane       (lane),
    .misalign   (misalign),
    .mem_rdata  (mem_rdata),
    .load_valid (load_valid),
    .load_data  (load_data)
  );

endmodule

// File: rtl/lsu_chk.sv
module lsu_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic [DATA_W-1:0]   store_data,
  input logic [DATA_W/8-1:0] mem_we,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic                misalign,
  input logic                load_valid,
  input logic [DATA_W-1:0]   load_data
);
  localparam int LANES = DATA_W / 8;

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |-> $countones(mem_we) == 1); // R4
  AST_BYTE_LANE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |-> mem_wdata == {LANES{store_data[7:0]}}); // R4
  AST_ALIGNED_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01 && !misalign) |-> (&mem_we)); // R3
  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> mem_we == '0); // R5
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !req_op[0]) |-> mem_we == '0); // R6
  AST_BYTE_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op[1]) |-> !misalign); // R2
  AST_LOAD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_op[0]) |=> load_valid); // R7
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_op[0]) |=> !load_valid); // R7
  AST_BYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b10) |=> load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}}); // R8
  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00 && misalign) |=> load_data == '0); // R9

endmodule

bind ls_unit lsu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .store_data (store_data),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .misalign   (misalign),
  .load_valid (load_valid),
  .load_data  (load_data)
);

// File: tb/sim_ls_unit.sv
module sim_ls_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] base;
  logic [15:0] offset;
  logic [31:0] store_data;
  logic [29:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        misalign;
  logic        load_valid;
  logic [31:0] load_data;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [7:0] bmem [256];
  logic [7:0] refm [256];

  always #4 clk = ~clk;

  ls_unit u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .base       (base),
    .offset     (offset),
    .store_data (store_data),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .misalign   (misalign),
    .load_valid (load_valid),
    .load_data  (load_data)
  );

  // behavioural byte memory, 64 words, synchronous read
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 8'(i * 37 + 5);
      mem_rdata <= '0;
    end else begin
      mem_rdata <= {bmem[{mem_addr[5:0], 2'd0}], bmem[{mem_addr[5:0], 2'd1}],
                    bmem[{mem_addr[5:0], 2'd2}], bmem[{mem_addr[5:0], 2'd3}]};
      for (int i = 0; i < 4; i++)
        if (mem_we[i]) bmem[{mem_addr[5:0], 2'(3 - i)}] <= mem_wdata[8*i +: 8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_we(input logic [1:0] op, input logic [7:0] ea);
    case (op)
      2'b01:   return (ea[1:0] == 2'd0) ? 4'b1111 : 4'b0000;
      2'b11:   return 4'b0001 << (3 - ea[1:0]);
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(input logic [1:0] op, input logic [7:0] ea);
    logic [7:0] w;
    w = {ea[7:2], 2'd0};
    if (op == 2'b00)
      return (ea[1:0] != 2'd0) ? 32'h0 : {refm[w], refm[w + 8'd1], refm[w + 8'd2], refm[w + 8'd3]};
    return {{24{refm[ea][7]}}, refm[ea]};
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [7:0] ea,
                       input logic [15:0] off, input logic [31:0] sd);
    logic [31:0] exp_ld;
    logic        word_bad;
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    offset     = off;
    store_data = sd;
    base       = {24'd0, ea} - {{16{off[15]}}, off};
    word_bad   = !op[1] && (ea[1:0] != 2'd0);
    #1;
    chk("R1 mem_addr", {2'b0, mem_addr}, {26'd0, ea[7:2]});
    chk("R2 misalign", {31'd0, misalign}, {31'd0, word_bad});
    if (op == 2'b01) chk(word_bad ? "R5 mem_we" : "R3 mem_we", {28'd0, mem_we}, {28'd0, exp_we(op, ea)});
    else if (op == 2'b11) chk("R4 mem_we", {28'd0, mem_we}, {28'd0, exp_we(op, ea)});
    else chk("R6 mem_we", {28'd0, mem_we}, 32'd0);
    if (op == 2'b01 && !word_bad) chk("R3 wdata", mem_wdata, sd);
    if (op == 2'b11) chk("R4 wdata", mem_wdata, {4{sd[7:0]}});
    exp_ld = op[0] ? 32'd0 : exp_load(op, ea);
    if (op == 2'b01 && !word_bad) begin
      refm[{ea[7:2], 2'd0}] = sd[31:24];
      refm[{ea[7:2], 2'd1}] = sd[23:16];
      refm[{ea[7:2], 2'd2}] = sd[15:8];
      refm[{ea[7:2], 2'd3}] = sd[7:0];
    end
    if (op == 2'b11) refm[ea] = sd[7:0];
    @(negedge clk);
    chk("R7 load_valid", {31'd0, load_valid}, {31'd0, !op[0]});
    if (op == 2'b00) chk(word_bad ? "R9 load_data" : "R11 load_data", load_data, exp_ld);
    if (op == 2'b10) chk("R8 load_data", load_data, exp_ld);
    req_valid = 1'b0;
    #1;
    chk("R6 idle mem_we", {28'd0, mem_we}, 32'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0]  op;
    logic [7:0]  ea;
    logic [31:0] r;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 37 + 5);
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00;
    base = '0; offset = '0; store_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 load_valid in reset", {31'd0, load_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 load_valid after reset", {31'd0, load_valid}, 32'd0);
    chk("R10 mem_we after reset", {28'd0, mem_we}, 32'd0);

    // lane placement: word then byte loads of every offset
    do_op(2'b01, 8'h10, 16'h0004, 32'h80112233);
    do_op(2'b10, 8'h10, 16'h0000, 32'h0);   // R8 0xFFFFFF80
    do_op(2'b10, 8'h13, 16'hFFF0, 32'h0);   // R8 0x00000033, negative offset R1
    do_op(2'b10, 8'h11, 16'h7FFF, 32'h0);
    do_op(2'b10, 8'h12, 16'h8000, 32'h0);
    // byte stores into each lane, neighbours must survive
    for (int k = 0; k < 4; k++) begin
      do_op(2'b11, 8'h20 + 8'(k), 16'(k * 3), 32'hABCDEF00 | 32'(8'hA0 + k));
      do_op(2'b00, 8'h20, 16'h0010, 32'h0);
    end
    // misaligned word store leaves memory intact, R5
    do_op(2'b01, 8'h41, 16'h0001, 32'hDEADBEEF);
    do_op(2'b01, 8'h43, 16'hFFFF, 32'hDEADBEEF);
    do_op(2'b00, 8'h40, 16'h0000, 32'h0);
    // misaligned word loads return zero, R9
    do_op(2'b00, 8'h42, 16'h0002, 32'h0);
    do_op(2'b00, 8'h01, 16'hFFFE, 32'h0);

    for (int n = 0; n < 800; n++) begin
      r  = $urandom;
      op = r[1:0];
      ea = r[9:2];
      if (!op[1] && r[12:10] != 3'd0) ea[1:0] = 2'd0;
      do_op(op, ea, 16'($urandom), $urandom);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule